// File: doc/BRIEF.md
# Maskable I/O Interrupt Sequencer

This block holds the interrupt state of a small accumulator machine that talks to one character input device and one character output device. It keeps a ready flag for each device, a global interrupt-enable bit and a pending-request bit. The pending bit is what the machine's control consults at each instruction boundary. When it is clear, the next instruction is fetched normally. When it is set, the first three timing slots of the next instruction are replaced by an interrupt cycle.

The interrupt cycle runs in three slots. The first points the address register at the save word and captures the program counter. The second writes the captured return address into memory word 0 and zeroes the program counter. The third bumps the program counter to 1, drops both the enable and the pending bit, and restarts the sequence counter. A handler starting at word 1 therefore runs with interrupts off until it turns them back on itself.

Requests are only raised outside the three fetch slots, so a request can never appear halfway through a fetch or halfway through an interrupt cycle.

Top module: `irq_ctl`

## Requirements
- R1: The input ready flag is set by `in_set` and cleared by `in_clr` on the next clock edge. When both strobes arrive in the same cycle, the flag is set.
- R2: The output ready flag is set by `out_set` and cleared by `out_clr` on the next clock edge. When both strobes arrive in the same cycle, the flag is set.
- R3: `en_on` sets the interrupt enable and `en_off` clears it on the next edge. When both arrive in the same cycle, the enable ends up cleared. Reset clears the enable, both flags and the pending bit.
- R4: The pending bit is set on the edge that closes a cycle in which all of the following hold: the enable is 1, at least one ready flag is 1, and `slot` is 3 or greater.
- R5: The pending bit is not set while the enable is 0, while both flags are 0, or while `slot` is 0, 1 or 2.
- R6: `fetch_sel` is 1 exactly when the pending bit is 0, so that an ordinary fetch follows.
- R7: Step 1 is the cycle with the pending bit at 1 and `slot` equal to 0. In that cycle `ar_load` is 1 with `ar_value` equal to 0, and `tr_load` is 1 with `tr_value` equal to `pc_in`. The value of `pc_in` is captured as the return address. At most one of `ar_load`, `mem_we` and `pc_inc` is 1 in any cycle.
- R8: Step 2 is the cycle with the pending bit at 1 and `slot` equal to 1. In that cycle `mem_we` is 1, `mem_addr` is 0, and `mem_wdata` holds the captured return address zero-extended. In the same cycle `pc_load` is 1 with `pc_value` equal to 0.
- R9: Step 3 is the cycle with the pending bit at 1 and `slot` equal to 2. In that cycle `pc_inc` and `sc_clr` are 1. After that edge, the pending bit and the enable are both 0, even if `en_on` arrived in the same cycle. The ready flags are left as they were.
- R10: While the pending bit is 0, `ar_load`, `tr_load`, `mem_we`, `pc_load`, `pc_inc` and `sc_clr` all stay 0, whatever the value of `slot`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_set | input | 1 | Input device has a character ready |
| in_clr | input | 1 | Program consumed the input character |
| out_set | input | 1 | Output device finished its character |
| out_clr | input | 1 | Program wrote a new output character |
| en_on | input | 1 | Interrupt-enable instruction strobe |
| en_off | input | 1 | Interrupt-disable instruction strobe |
| slot | input | SLOT_W | Current timing slot index from the sequence counter |
| pc_in | input | ADDR_W | Current program counter |
| fetch_sel | output | 1 | 1 selects a normal fetch at the boundary |
| ar_load | output | 1 | Load address register |
| ar_value | output | ADDR_W | Value for the address register |
| tr_load | output | 1 | Load temporary register |
| tr_value | output | ADDR_W | Value for the temporary register |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | ADDR_W | Memory write address |
| mem_wdata | output | WORD_W | Memory write data |
| pc_load | output | 1 | Load program counter |
| pc_value | output | ADDR_W | Value for the program counter |
| pc_inc | output | 1 | Increment program counter |
| sc_clr | output | 1 | Clear sequence counter |
| irq_en | output | 1 | Interrupt enable state |
| in_flag | output | 1 | Input ready flag |
| out_flag | output | 1 | Output ready flag |
| pend | output | 1 | Pending interrupt request |

## Verification
The collision that matters is between the last step of the interrupt cycle, which forces the enable off, and an enable-on strobe arriving in the same cycle. The bench drives `en_on` during step 3 and then checks that the enable and the pending bit are both 0 after that edge. Set and clear strobes on one flag are also driven together. The bench judges those by the flag value on the following cycle. A sweep over every combination of enable, both flags and all sixteen slot values then compares the pending bit against the arithmetic rule.

// File: rtl/irq_ctl_pkg.sv
package irq_ctl_pkg;

    // Number of leading timing slots taken by fetch or by the interrupt cycle.
    localparam int unsigned FETCH_SLOTS = 3;

    typedef enum logic [1:0] {
        STEP_IDLE,
        STEP_PREP,
        STEP_STORE,
        STEP_RESUME
    } irq_step_e;

    typedef struct packed {
        logic enable;
        logic in_rdy;
        logic out_rdy;
    } irq_state_t;

    typedef struct packed {
        logic ar_load;
        logic tr_load;
        logic mem_we;
        logic pc_load;
        logic pc_inc;
        logic sc_clr;
    } irq_ctrl_t;

    // Map the slot index to an interrupt-cycle step; only meaningful when a request pends.
    function automatic irq_step_e step_of(input logic pending, input int unsigned slot_idx);
        if (!pending)
            return STEP_IDLE;
        case (slot_idx)
            0:       return STEP_PREP;
            1:       return STEP_STORE;
            2:       return STEP_RESUME;
            default: return STEP_IDLE;
        endcase
    endfunction

endpackage

// File: rtl/irq_flag_cell.sv
module irq_flag_cell #(
    parameter bit SET_WINS = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    output logic q_o
);
    logic nxt;

    generate
        if (SET_WINS) begin : g_set_first
            always_comb begin
                if (set_i)      nxt = 1'b1;
                else if (clr_i) nxt = 1'b0;
                else            nxt = q_o;
            end
        end else begin : g_clr_first
            always_comb begin
                if (clr_i)      nxt = 1'b0;
                else if (set_i) nxt = 1'b1;
                else            nxt = q_o;
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) q_o <= 1'b0;
        else     q_o <= nxt;
    end
endmodule

// File: rtl/irq_req.sv
module irq_req
    import irq_ctl_pkg::*;
#(
    parameter int unsigned SLOT_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  irq_state_t        st_i,
    input  logic [SLOT_W-1:0] slot_i,
    input  logic              done_i,
    output logic              pend_o
);
    localparam logic [SLOT_W-1:0] FIRST_OPEN = SLOT_W'(FETCH_SLOTS);

    logic raise;

    assign raise = st_i.enable && (st_i.in_rdy || st_i.out_rdy) && (slot_i >= FIRST_OPEN);

    always_ff @(posedge clk) begin
        if (rst)         pend_o <= 1'b0;
        else if (done_i) pend_o <= 1'b0;
        else if (raise)  pend_o <= 1'b1;
    end
endmodule

// File: rtl/irq_seq.sv
module irq_seq
    import irq_ctl_pkg::*;
#(
    parameter int unsigned ADDR_W    = 12,
    parameter int unsigned WORD_W    = 16,
    parameter int unsigned SLOT_W    = 4,
    parameter int unsigned SAVE_ADDR = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pend_i,
    input  logic [SLOT_W-1:0] slot_i,
    input  logic [ADDR_W-1:0] pc_i,
    output irq_ctrl_t         ctrl_o,
    output logic [ADDR_W-1:0] save_addr_o,
    output logic [WORD_W-1:0] save_data_o,
    output logic [ADDR_W-1:0] target_o,
    output logic              done_o
);
    localparam logic [ADDR_W-1:0] SAVE_A = ADDR_W'(SAVE_ADDR);
    localparam int unsigned       PAD_W  = WORD_W - ADDR_W;

    irq_step_e         step;
    logic [ADDR_W-1:0] ret_q;

    assign step = step_of(pend_i, int'(slot_i));

    always_ff @(posedge clk) begin
        if (rst)                    ret_q <= '0;
        else if (step == STEP_PREP) ret_q <= pc_i;
    end

    always_comb begin
        ctrl_o = '0;
        unique case (step)
            STEP_PREP: begin
                ctrl_o.ar_load = 1'b1;
                ctrl_o.tr_load = 1'b1;
            end
            STEP_STORE: begin
                ctrl_o.mem_we  = 1'b1;
                ctrl_o.pc_load = 1'b1;
            end
            STEP_RESUME: begin
                ctrl_o.pc_inc = 1'b1;
                ctrl_o.sc_clr = 1'b1;
            end
            default: ctrl_o = '0;
        endcase
    end

    assign save_addr_o = SAVE_A;
    assign target_o    = SAVE_A;
    assign save_data_o = {{PAD_W{1'b0}}, ret_q};
    assign done_o      = (step == STEP_RESUME);
endmodule

// File: rtl/irq_ctl.sv
module irq_ctl
    import irq_ctl_pkg::*;
#(
    parameter int unsigned ADDR_W = 12,
    parameter int unsigned WORD_W = 16,
    parameter int unsigned SLOT_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_set,
    input  logic              in_clr,
    input  logic              out_set,
    input  logic              out_clr,
    input  logic              en_on,
    input  logic              en_off,
    input  logic [SLOT_W-1:0] slot,
    input  logic [ADDR_W-1:0] pc_in,
    output logic              fetch_sel,
    output logic              ar_load,
    output logic [ADDR_W-1:0] ar_value,
    output logic              tr_load,
    output logic [ADDR_W-1:0] tr_value,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    output logic              pc_load,
    output logic [ADDR_W-1:0] pc_value,
    output logic              pc_inc,
    output logic              sc_clr,
    output logic              irq_en,
    output logic              in_flag,
    output logic              out_flag,
    output logic              pend
);
    irq_state_t st;
    irq_ctrl_t  ctrl;
    logic       done;
    logic       en_kill;

    assign en_kill = en_off | done;

    irq_flag_cell #(.SET_WINS(1'b1)) u_in_flag (
        .clk(clk), .rst(rst), .set_i(in_set), .clr_i(in_clr), .q_o(st.in_rdy)
    );

    irq_flag_cell #(.SET_WINS(1'b1)) u_out_flag (
        .clk(clk), .rst(rst), .set_i(out_set), .clr_i(out_clr), .q_o(st.out_rdy)
    );

    irq_flag_cell #(.SET_WINS(1'b0)) u_enable (
        .clk(clk), .rst(rst), .set_i(en_on), .clr_i(en_kill), .q_o(st.enable)
    );

    irq_req #(.SLOT_W(SLOT_W)) u_req (
        .clk(clk), .rst(rst), .st_i(st), .slot_i(slot), .done_i(done), .pend_o(pend)
    );

    irq_seq #(
        .ADDR_W(ADDR_W), .WORD_W(WORD_W), .SLOT_W(SLOT_W), .SAVE_ADDR(0)
    ) u_seq (
        .clk(clk), .rst(rst), .pend_i(pend), .slot_i(slot), .pc_i(pc_in),
        .ctrl_o(ctrl), .save_addr_o(mem_addr), .save_data_o(mem_wdata),
        .target_o(pc_value), .done_o(done)
    );

    assign fetch_sel = ~pend;
    assign ar_load   = ctrl.ar_load;
    assign ar_value  = mem_addr;
    assign tr_load   = ctrl.tr_load;
    assign tr_value  = pc_in;
    assign mem_we    = ctrl.mem_we;
    assign pc_load   = ctrl.pc_load;
    assign pc_inc    = ctrl.pc_inc;
    assign sc_clr    = ctrl.sc_clr;
    assign irq_en    = st.enable;
    assign in_flag   = st.in_rdy;
    assign out_flag  = st.out_rdy;
endmodule

// File: rtl/irq_ctl_chk.sv
module irq_ctl_chk #(
    parameter int unsigned ADDR_W = 12,
    parameter int unsigned SLOT_W = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              in_set,
    input logic              en_off,
    input logic [SLOT_W-1:0] slot,
    input logic              pend,
    input logic              irq_en,
    input logic              in_flag,
    input logic              out_flag,
    input logic              ar_load,
    input logic              tr_load,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              pc_load,
    input logic              pc_inc,
    input logic              sc_clr
);
    localparam logic [SLOT_W-1:0] OPEN = SLOT_W'(3);

    AST_IN_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        in_set |=> in_flag); // R1

    AST_EN_OFF_WINS: assert property (@(posedge clk) disable iff (rst)
        en_off |=> !irq_en); // R3

    AST_PEND_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $rose(pend) |-> $past(irq_en && (in_flag || out_flag) && (slot >= OPEN))); // R4

    AST_NO_PEND_EARLY: assert property (@(posedge clk) disable iff (rst)
        (!pend && (slot < OPEN)) |=> !pend); // R5

    AST_ONE_STEP: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ar_load, mem_we, pc_inc})); // R7

    AST_STORE_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> (mem_addr == '0) && pc_load); // R8

    AST_RESUME_CLEARS: assert property (@(posedge clk) disable iff (rst)
        pc_inc |=> (!pend && !irq_en)); // R9

    AST_QUIET_NORMAL: assert property (@(posedge clk) disable iff (rst)
        !pend |-> !(ar_load || tr_load || mem_we || pc_load || pc_inc || sc_clr)); // R10
endmodule

bind irq_ctl irq_ctl_chk #(.ADDR_W(ADDR_W), .SLOT_W(SLOT_W)) u_chk (
    .clk(clk), .rst(rst), .in_set(in_set), .en_off(en_off), .slot(slot),
    .pend(pend), .irq_en(irq_en), .in_flag(in_flag), .out_flag(out_flag),
    .ar_load(ar_load), .tr_load(tr_load), .mem_we(mem_we), .mem_addr(mem_addr),
    .pc_load(pc_load), .pc_inc(pc_inc), .sc_clr(sc_clr)
);

// File: tb/irq_ctl_tb.sv
module irq_ctl_tb;
    localparam int ADDR_W = 12;
    localparam int WORD_W = 16;
    localparam int SLOT_W = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_set = 0, in_clr = 0, out_set = 0, out_clr = 0, en_on = 0, en_off = 0;
    logic [SLOT_W-1:0] slot = '0;
    logic [ADDR_W-1:0] pc_in = '0;
    logic fetch_sel, ar_load, tr_load, mem_we, pc_load, pc_inc, sc_clr;
    logic irq_en, in_flag, out_flag, pend;
    logic [ADDR_W-1:0] ar_value, tr_value, mem_addr, pc_value;
    logic [WORD_W-1:0] mem_wdata;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #2 clk = ~clk;

    irq_ctl #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .SLOT_W(SLOT_W)) u_dut (
        .clk(clk), .rst(rst), .in_set(in_set), .in_clr(in_clr), .out_set(out_set),
        .out_clr(out_clr), .en_on(en_on), .en_off(en_off), .slot(slot), .pc_in(pc_in),
        .fetch_sel(fetch_sel), .ar_load(ar_load), .ar_value(ar_value), .tr_load(tr_load),
        .tr_value(tr_value), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .pc_load(pc_load), .pc_value(pc_value), .pc_inc(pc_inc), .sc_clr(sc_clr),
        .irq_en(irq_en), .in_flag(in_flag), .out_flag(out_flag), .pend(pend)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic clear_strobes();
        in_set = 0; in_clr = 0; out_set = 0; out_clr = 0; en_on = 0; en_off = 0;
    endtask

    task automatic do_reset();
        clear_strobes();
        slot = '0;
        rst = 1;
        tick();
        rst = 0;
    endtask

    function automatic logic [5:0] ctrl_vec();
        return {ar_load, tr_load, mem_we, pc_load, pc_inc, sc_clr};
    endfunction

    initial begin
        #1;
        do_reset();
        // R3 reset state
        check("R3 reset enable", irq_en, 0);
        check("R3 reset in flag", in_flag, 0);
        check("R3 reset out flag", out_flag, 0);
        check("R3 reset pend", pend, 0);
        check("R6 fetch after reset", fetch_sel, 1);

        // R1 and R2 strobe collisions
        in_set = 1; in_clr = 1; out_set = 1; out_clr = 1; tick(); clear_strobes();
        check("R1 set beats clear", in_flag, 1);
        check("R2 set beats clear", out_flag, 1);
        in_clr = 1; tick(); clear_strobes();
        check("R1 clear", in_flag, 0);
        check("R2 untouched by in_clr", out_flag, 1);
        out_clr = 1; tick(); clear_strobes();
        check("R2 clear", out_flag, 0);

        // R3 enable collisions
        en_on = 1; tick(); clear_strobes();
        check("R3 enable on", irq_en, 1);
        en_on = 1; en_off = 1; tick(); clear_strobes();
        check("R3 off beats on", irq_en, 0);

        // R4 R5 R6 R10 sweep over enable, flags and every slot
        for (int combo = 0; combo < 8; combo++) begin
            for (int s = 0; s < (1 << SLOT_W); s++) begin
                logic exp_p;
                do_reset();
                en_on = combo[2]; in_set = combo[1]; out_set = combo[0];
                tick(); clear_strobes();
                slot = SLOT_W'(s);
                if (pend != 0) check("R5 no early pend", pend, 0);
                if (ctrl_vec() != 0) check("R10 quiet when idle", 32'(ctrl_vec()), 0);
                tick();
                exp_p = combo[2] && (combo[1] || combo[0]) && (s >= 3);
                check(exp_p ? "R4 pend raised" : "R5 pend held off", pend, exp_p);
                check("R6 fetch select", fetch_sel, !exp_p);
                slot = 4'd9;
            end
        end

        // R7 R8 R9 full interrupt cycle with several return addresses
        for (int k = 0; k < 4; k++) begin
            logic [ADDR_W-1:0] ret;
            ret = ADDR_W'(12'h0A5 + k * 12'h3C1);
            do_reset();
            en_on = 1; out_set = 1; tick(); clear_strobes();
            slot = 4'd7; tick();
            check("R4 pend for cycle", pend, 1);
            slot = 4'd0; pc_in = ret; #1;
            check("R7 step1 controls", 32'(ctrl_vec()), 32'b110000);
            check("R7 ar value", ar_value, 0);
            check("R7 tr value", tr_value, ret);
            tick();
            slot = 4'd1; pc_in = ~ret; #1;
            check("R8 step2 controls", 32'(ctrl_vec()), 32'b001100);
            check("R8 mem addr", mem_addr, 0);
            check("R8 saved return", mem_wdata, 32'(ret));
            check("R8 pc value", pc_value, 0);
            tick();
            slot = 4'd2; en_on = (k % 2 == 0); #1;
            check("R9 step3 controls", 32'(ctrl_vec()), 32'b000011);
            tick(); clear_strobes();
            slot = 4'd0; #1;
            check("R9 pend cleared", pend, 0);
            check("R9 enable cleared despite en_on", irq_en, 0);
            check("R9 flag kept", out_flag, 1);
            check("R6 fetch resumes", fetch_sel, 1);
            check("R10 quiet after cycle", 32'(ctrl_vec()), 0);
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule